// File: doc/BRIEF.md
# Serial Clock Waveform Generator

This block turns the system clock into the clock line of a two-wire bus master. It produces a level for the clock line and two single-cycle strobes that mark the rising and falling transitions. The bus engine uses the strobes to decide when to move data and when to sample it. Each half of the waveform has its own divider, and both dividers share one power-of-two prescale exponent. Every half period also carries a fixed overhead of three system clocks.

Software chooses the divider values and places them in a packed configuration word, so the block does no frequency search. An enable input starts and stops the waveform. A hold input lets the bus engine stretch the low half for as long as it needs. Each phase length is taken from the configuration word at the moment that phase begins. A new setting therefore never cuts a phase short or makes one longer once it has started.

Top module: `scl_wavegen`

## Requirements
- R1: After reset the clock level is 1 and both strobes are 0.
- R2: While enable is 0 the clock level is 1 and no strobe fires. If enable is sampled 0 while the level is 0, the level returns to 1 on that clock edge with a rise strobe. If enable is sampled 0 while the level is 1, no strobe fires.
- R3: A low phase lasts (L << E) + 3 system clocks, where L = cfg_word[7:0] and E = cfg_word[18:16].
- R4: A high phase lasts (H << E) + 3 system clocks, where H = cfg_word[15:8].
- R5: On the first clock edge at which enable is sampled 1 from idle, the level drops to 0 with a fall strobe, so the waveform starts with a low phase.
- R6: Each edge at which hold is sampled 1 during a low phase lengthens that low phase by one system clock.
- R7: Hold has no effect during a high phase.
- R8: A change to cfg_word in the middle of a phase leaves that phase's length unchanged. The new value sets the length of the following phases.
- R9: The rise strobe is 1 for exactly the cycles in which the level has just gone from 0 to 1, and the fall strobe for those in which it has just gone from 1 to 0. The two strobes are never 1 together.
- R10: The extremes of the range are exact. Dividers of 0 give 3-clock phases, and dividers of 255 with E = 7 give 32643-clock phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_word | input | 19 | {exponent[2:0], high divider[7:0], low divider[7:0]} |
| en | input | 1 | Run the waveform when 1; idle high when 0 |
| hold | input | 1 | Stretch the current low phase |
| scl_o | output | 1 | Clock line level |
| scl_rise_o | output | 1 | One-cycle strobe on a 0 to 1 transition |
| scl_fall_o | output | 1 | One-cycle strobe on a 1 to 0 transition |

## Verification
The assertions assume that reset is applied before any enable. They also assume that enable, hold and the configuration word are steady around each rising edge. Under those conditions, the level can change only when the phase counter has run out or enable has dropped. A sampled hold in the low phase freezes both the count and the level.

The stimulus drives all inputs on the falling clock edge. It asserts hold only in whole-cycle windows that fit inside a single phase. It changes the configuration only just after an observed strobe, so every expected phase length follows from the setting that was present when that phase began.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    // Waveform state: idle (released high), driving low, driving high.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Fixed overhead added to every half period, in system clocks.
    localparam int unsigned HALF_OVERHEAD = 3;

endpackage

// File: rtl/sclgen_len.sv
// Converts one divider and the shared exponent into a terminal count
// (phase length minus one) for the phase timer.
module sclgen_len #(
    parameter int DIV_W = 8,
    parameter int EXP_W = 3,
    parameter int CNT_W = DIV_W + (1 << EXP_W)
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic [CNT_W-1:0] last_o
);
    import sclgen_pkg::*;

    logic [CNT_W-1:0] scaled;

    always_comb begin
        scaled = CNT_W'(div_i) << exp_i;
        last_o = scaled + CNT_W'(HALF_OVERHEAD - 1);
    end

endmodule

// File: rtl/sclgen_timer.sv
// Phase sequencer: down-counter reloaded at each phase boundary,
// registered clock level and edge strobes.
module sclgen_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hold,
    input  logic [CNT_W-1:0] low_last,
    input  logic [CNT_W-1:0] high_last,
    output logic             scl_o,
    output logic             rise_o,
    output logic             fall_o
);
    import sclgen_pkg::*;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             scl;
        logic             rise;
        logic             fall;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
            st_d.scl = 1'b1;
        end else begin
            case (st_q.ph)
                PH_IDLE: begin
                    st_d.ph  = PH_LOW;
                    st_d.scl = 1'b0;
                    st_d.cnt = low_last;
                end
                PH_LOW: begin
                    if (!hold) begin
                        if (st_q.cnt == '0) begin
                            st_d.ph  = PH_HIGH;
                            st_d.scl = 1'b1;
                            st_d.cnt = high_last;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                end
                PH_HIGH: begin
                    if (st_q.cnt == '0) begin
                        st_d.ph  = PH_LOW;
                        st_d.scl = 1'b0;
                        st_d.cnt = low_last;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                default: begin
                    st_d.ph  = PH_IDLE;
                    st_d.scl = 1'b1;
                    st_d.cnt = '0;
                end
            endcase
        end
        st_d.rise = st_d.scl & ~st_q.scl;
        st_d.fall = ~st_d.scl & st_q.scl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.cnt  <= '0;
            st_q.scl  <= 1'b1;
            st_q.rise <= 1'b0;
            st_q.fall <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_o  = st_q.scl;
    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> scl_o);

    assert_no_early_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.cnt != '0) |=> $stable(scl_o));

    assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hold && st_q.ph == PH_LOW) |=> (!scl_o && $stable(st_q.cnt)));

    assert_rise_marks_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (scl_o && !$past(scl_o)));

    assert_fall_marks_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> (!scl_o && $past(scl_o)));

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));

endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen #(
    parameter int DIV_W = 8,
    parameter int EXP_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*DIV_W+EXP_W-1:0] cfg_word,
    input  logic                     en,
    input  logic                     hold,
    output logic                     scl_o,
    output logic                     scl_rise_o,
    output logic                     scl_fall_o
);
    localparam int CNT_W = DIV_W + (1 << EXP_W);
    localparam int N_HALF = 2;

    logic [N_HALF-1:0][DIV_W-1:0] divs;
    logic [N_HALF-1:0][CNT_W-1:0] lasts;
    logic [EXP_W-1:0]             expo;

    // Index 0 is the low half, index 1 the high half.
    assign divs[0] = cfg_word[DIV_W-1:0];
    assign divs[1] = cfg_word[2*DIV_W-1:DIV_W];
    assign expo    = cfg_word[2*DIV_W+EXP_W-1:2*DIV_W];

    for (genvar g = 0; g < N_HALF; g++) begin : g_half
        sclgen_len #(
            .DIV_W (DIV_W),
            .EXP_W (EXP_W),
            .CNT_W (CNT_W)
        ) u_len (
            .div_i  (divs[g]),
            .exp_i  (expo),
            .last_o (lasts[g])
        );
    end

    sclgen_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .hold      (hold),
        .low_last  (lasts[0]),
        .high_last (lasts[1]),
        .scl_o     (scl_o),
        .rise_o    (scl_rise_o),
        .fall_o    (scl_fall_o)
    );

endmodule

// File: tb/sim_scl_wavegen.sv
module sim_scl_wavegen;

    typedef struct {
        bit    is_rise;
        int    gap;
        string tag;
    } evt_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] cfg_word = '0;
    logic        en = 1'b0;
    logic        hold = 1'b0;
    logic        scl, rise, fall;

    int   nchk = 0;
    int   nfail = 0;
    int   cyc = 0;
    int   last_evt = 0;
    bit   done = 0;
    evt_t exp_q[$];

    always #10 clk = ~clk;

    scl_wavegen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_word   (cfg_word),
        .en         (en),
        .hold       (hold),
        .scl_o      (scl),
        .scl_rise_o (rise),
        .scl_fall_o (fall)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int plen(int d, int e);
        return d * (1 << e) + 3;
    endfunction

    task automatic push(bit r, int g, string t);
        evt_t x;
        x.is_rise = r; x.gap = g; x.tag = t;
        exp_q.push_back(x);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
    endtask

    task automatic start(int lo, int hi, int ex);
        cfg_word = {ex[2:0], hi[7:0], lo[7:0]};
        en = 1'b1;
        last_evt = cyc;
        push(0, 1, "R5");
    endtask

    task automatic pairs(int lo_len, int hi_len, int n, string tl, string th);
        for (int i = 0; i < n; i++) begin
            push(1, lo_len, tl);
            push(0, hi_len, th);
        end
    endtask

    task automatic stop_in_low();
        drain();
        en = 1'b0;
        push(1, 1, "R2");
        drain();
    endtask

    task automatic idle_check(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            nchk++;
            if (scl !== 1'b1 || rise !== 1'b0 || fall !== 1'b0) begin
                nfail++;
                $display("FAIL R2 idle: scl=%0b rise=%0b fall=%0b expected 1/0/0", scl, rise, fall);
            end
        end
    endtask

    // Monitor: compares each observed strobe with the next expected item.
    bit prev_scl = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rise || fall) begin
                nchk++;
                if (exp_q.size() == 0) begin
                    nfail++;
                    $display("FAIL R2 unexpected strobe rise=%0b fall=%0b expected none", rise, fall);
                end else begin
                    evt_t x;
                    x = exp_q.pop_front();
                    if (rise !== x.is_rise || fall === x.is_rise || scl !== x.is_rise) begin
                        nfail++;
                        $display("FAIL R9 %s kind: rise=%0b fall=%0b scl=%0b expected rise=%0b",
                                 x.tag, rise, fall, scl, x.is_rise);
                    end
                    if (x.gap >= 0 && (cyc - last_evt) != x.gap) begin
                        nfail++;
                        $display("FAIL %s gap: actual=%0d expected=%0d", x.tag, cyc - last_evt, x.gap);
                    end
                end
                last_evt = cyc;
            end else if (scl !== prev_scl) begin
                nchk++;
                nfail++;
                $display("FAIL R9 level changed without strobe: actual=%0b expected=%0b", scl, prev_scl);
            end
            prev_scl = scl;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        nchk++;
        if (scl !== 1'b1 || rise !== 1'b0 || fall !== 1'b0) begin
            nfail++;
            $display("FAIL R1 in reset: scl=%0b rise=%0b fall=%0b expected 1/0/0", scl, rise, fall);
        end
        rst_n = 1'b1;
        idle_check(4);

        // Symmetric setting, no prescale (R3, R4, R5)
        start(2, 2, 0);
        pairs(plen(2, 0), plen(2, 0), 2, "R3", "R4");
        stop_in_low();
        idle_check(6);

        // Minimum dividers (R10)
        start(0, 0, 0);
        pairs(3, 3, 3, "R10", "R10");
        stop_in_low();

        // Asymmetric with prescale (R3, R4)
        start(3, 1, 2);
        pairs(plen(3, 2), plen(1, 2), 2, "R3", "R4");
        stop_in_low();

        // Largest exponent, disable during the high phase (R2)
        start(1, 2, 7);
        pairs(plen(1, 7), plen(2, 7), 1, "R3", "R4");
        push(1, plen(1, 7), "R3");
        drain();
        en = 1'b0;
        idle_check(8);

        // Hold during low stretches it (R6); during high it is ignored (R7)
        start(2, 2, 0);
        drain();
        push(1, plen(2, 0) + 4, "R6");
        hold = 1'b1;
        repeat (4) @(negedge clk);
        hold = 1'b0;
        drain();
        hold = 1'b1;
        push(0, plen(2, 0), "R7");
        drain();
        hold = 1'b0;
        pairs(plen(2, 0), plen(2, 0), 1, "R6", "R7");
        stop_in_low();

        // Configuration change mid phase (R8)
        start(1, 1, 0);
        drain();
        cfg_word = {3'd1, 8'd3, 8'd4};
        push(1, plen(1, 0), "R8");
        push(0, plen(3, 1), "R8");
        push(1, plen(4, 1), "R8");
        push(0, plen(3, 1), "R8");
        stop_in_low();

        // Maximum dividers and exponent (R10)
        start(255, 255, 7);
        push(1, 32643, "R10");
        push(0, 32643, "R10");
        stop_in_low();
        idle_check(4);

        finish_run();
    end

endmodule